// File: doc/BRIEF.md
# Programmable-Order Fractional-N Delta-Sigma Modulator

This block sits between the channel configuration of a fractional-N synthesizer and its feedback divider. On every reference clock edge it emits a small signed offset that the divider adds to its integer ratio. Over time the offsets average to `frac_num / frac_den`, so the synthesizer lands between integer multiples of the reference. The denominator can be any value from 1 to 4095. It does not have to be a power of two, so a ratio such as 400/4000 is accepted exactly as readily as 1/10, and both give the same mean.

Inside, up to four modulo-denominator accumulators are cascaded. The first one takes the numerator, optionally disturbed by a zero-mean pseudo-random dither. Each following stage takes the wrapped residue of the stage before it. The carries of the stages are recombined through binomial difference filters so that the quantisation noise of the later stages cancels in the sum. Three noise-shaping orders are selectable. Dither has three strengths, and one spare code repeats the strongest.

Top module: `frac_dsm`

## Requirements
- R1: A synchronous active-high reset clears every accumulator, every carry history, the dither history and the output to 0, and seeds the dither generator with 1. On the first falling clock edge after a reset edge, `div_offset` reads 0.
- R2: `order_code` selects the number of active stages as follows: 2 gives second order, 3 gives third order and 0 gives fourth order. Code 1 falls back to third order. Stages above the selected order hold zero and contribute nothing.
- R3: `frac_den` and `order_code` are captured only on clock edges where reset is high. Changes on those inputs at any other time do not alter the output sequence.
- R4: With dither off, the sum of the outputs over the first K·den cycles after reset lies within ±4 of K·num for every order. This applies to equivalent ratios too (1/10 and 400/4000).
- R5: With `frac_num` = 0 and dither off since reset, `div_offset` is 0 on every cycle.
- R6: With dither off in the current and the previous cycle, the output stays within -1..+2 for second order, -3..+4 for third order and -7..+8 for fourth order.
- R7: The dither source is a 15-bit shift register. It shifts left every cycle and feeds in bit14 XOR bit13. `dither_code` 0 applies no bits, code 1 applies bit 0, and codes 2 and 3 apply bits 1:0. The value applied to the first stage is this cycle's applied bits minus the previous cycle's.
- R8: When the captured denominator is below 4, dither is forced off whatever `dither_code` says.
- R9: Each later stage adds the new residue of the stage before it to its own residue. A result at or above den subtracts den and carries 1. The first stage adds numerator and dither and can carry -1, 0, 1 or 2, so that its residue always stays in 0..den-1.
- R10: `div_offset` is registered. After the edge for cycle n it equals c1[n] + Δc2[n] + Δ²c3[n] + Δ³c4[n], where Δ is the backward difference and ck is the carry of stage k in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; also captures denominator and order |
| frac_num | input | DEN_W | Fractional numerator, below the denominator |
| frac_den | input | DEN_W | Fractional denominator (modulus), 1..4095 |
| order_code | input | 2 | Order select: 2, 3, 0 → second, third, fourth order |
| dither_code | input | 2 | Dither strength: 0 off, 1 weak, 2/3 strong |
| div_offset | output | OUT_W | Signed divide-ratio offset for the feedback divider |

## Verification
The hardest cycles are those where a dither step pulls the first-stage sum below zero or pushes it past twice the denominator. In those cycles the head stage borrows or double-carries while the later stages carry off the same freshly wrapped residue, and all of it is folded into one output. The bench provokes this with strong dither on numerators of 0 and den-1 and on a denominator of 4. It judges every cycle against an integer model that tracks the residues, carry histories and dither register on its own. Dither-off runs add the long-run mean check and the per-order output bounds on top.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    localparam int DSM_MAX_ORDER = 4;
    localparam int CARRY_W       = 3;

    typedef logic signed [CARRY_W-1:0] carry_t;

    typedef enum logic [2:0] {
        ORDER_2 = 3'd2,
        ORDER_3 = 3'd3,
        ORDER_4 = 3'd4
    } order_e;

    typedef enum logic [1:0] {
        DITH_NONE      = 2'd0,
        DITH_LIGHT     = 2'd1,
        DITH_HEAVY     = 2'd2,
        DITH_HEAVY_ALT = 2'd3
    } dith_e;

    // Map the coded order field onto a stage count; the spare code falls back to third order.
    function automatic order_e order_decode(input logic [1:0] code);
        case (code)
            2'd2:    return ORDER_2;
            2'd0:    return ORDER_4;
            default: return ORDER_3;
        endcase
    endfunction

    // Which random bits a dither level lets through.
    function automatic logic [1:0] dith_mask(input dith_e lvl);
        case (lvl)
            DITH_NONE:  return 2'b00;
            DITH_LIGHT: return 2'b01;
            default:    return 2'b11;
        endcase
    endfunction

    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) begin
            r = r * (n - i) / (i + 1);
        end
        return r;
    endfunction

    function automatic logic stage_on(input order_e ord, input int idx);
        return idx < int'(ord);
    endfunction

endpackage

// File: rtl/dsm_dither.sv
module dsm_dither
    import dsm_pkg::*;
#(
    parameter int                LFSR_W = 15,
    parameter logic [LFSR_W-1:0] SEED   = LFSR_W'(1)
) (
    input  logic   clk,
    input  logic   rst,
    input  dith_e  level,
    input  logic   allow,
    output carry_t step
);
    localparam int TAP_HI = LFSR_W - 1;
    localparam int TAP_LO = LFSR_W - 2;

    logic [LFSR_W-1:0] lfsr_q;
    logic [1:0]        applied;
    logic [1:0]        prev_q;

    always_comb begin
        applied = allow ? (lfsr_q[1:0] & dith_mask(level)) : 2'b00;
    end

    // First difference of the applied bits: zero mean, telescoping sum.
    always_comb begin
        step = $signed({1'b0, applied}) - $signed({1'b0, prev_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= SEED;
            prev_q <= 2'b00;
        end else begin
            lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[TAP_HI] ^ lfsr_q[TAP_LO]};
            prev_q <= applied;
        end
    end

endmodule

// File: rtl/dsm_stage.sv
module dsm_stage
    import dsm_pkg::*;
#(
    parameter int DEN_W = 12,
    parameter bit HEAD  = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    active,
    input  logic signed [DEN_W+2:0] addend,
    input  logic [DEN_W-1:0]        modulus,
    output logic [DEN_W-1:0]        acc_nx,
    output carry_t                  carry
);
    localparam int SUM_W = DEN_W + 3;

    logic [DEN_W-1:0]        acc_q;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] mod1;
    logic signed [SUM_W-1:0] wrapped;
    carry_t                  raw_c;

    always_comb begin
        mod1 = $signed({3'b000, modulus});
        sum  = $signed({3'b000, acc_q}) + addend;
    end

    generate
        if (HEAD) begin : g_head
            logic signed [SUM_W-1:0] mod2;
            always_comb begin
                mod2 = mod1 <<< 1;
                if (sum < 0) begin
                    raw_c   = -3'sd1;
                    wrapped = sum + mod1;
                end else if (sum >= mod2) begin
                    raw_c   = 3'sd2;
                    wrapped = sum - mod2;
                end else if (sum >= mod1) begin
                    raw_c   = 3'sd1;
                    wrapped = sum - mod1;
                end else begin
                    raw_c   = 3'sd0;
                    wrapped = sum;
                end
            end
        end else begin : g_tail
            always_comb begin
                if (sum >= mod1) begin
                    raw_c   = 3'sd1;
                    wrapped = sum - mod1;
                end else begin
                    raw_c   = 3'sd0;
                    wrapped = sum;
                end
            end
        end
    endgenerate

    always_comb begin
        acc_nx = active ? DEN_W'(wrapped) : '0;
        carry  = active ? raw_c : 3'sd0;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_nx;
        end
    end

endmodule

// File: rtl/dsm_combiner.sv
module dsm_combiner
    import dsm_pkg::*;
#(
    parameter int NST   = 4,
    parameter int OUT_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  carry_t                  cy [NST],
    output logic signed [OUT_W-1:0] y_q
);
    localparam int TW = OUT_W + 2;

    logic [NST-1:0][TW-1:0] terms;
    logic signed [TW-1:0]   total;

    generate
        for (genvar i = 0; i < NST; i++) begin : g_path
            if (i == 0) begin : g_direct
                assign terms[i] = TW'(cy[i]);
            end else begin : g_diff
                carry_t               hist_q [i];
                logic signed [TW-1:0] part;

                always_ff @(posedge clk) begin
                    if (rst) begin
                        for (int k = 0; k < i; k++) begin
                            hist_q[k] <= 3'sd0;
                        end
                    end else begin
                        hist_q[0] <= cy[i];
                        for (int k = 1; k < i; k++) begin
                            hist_q[k] <= hist_q[k-1];
                        end
                    end
                end

                // i-th backward difference of this stage's carry stream.
                always_comb begin
                    part = TW'(cy[i]);
                    for (int j = 1; j <= i; j++) begin
                        if ((j % 2) == 1) begin
                            part = part - TW'(binom(i, j)) * TW'(hist_q[j-1]);
                        end else begin
                            part = part + TW'(binom(i, j)) * TW'(hist_q[j-1]);
                        end
                    end
                end

                assign terms[i] = part;
            end
        end
    endgenerate

    always_comb begin
        total = '0;
        for (int i = 0; i < NST; i++) begin
            total = total + $signed(terms[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
        end else begin
            y_q <= OUT_W'(total);
        end
    end

endmodule

// File: rtl/frac_dsm.sv
module frac_dsm
    import dsm_pkg::*;
#(
    parameter int DEN_W        = 12,
    parameter int OUT_W        = 5,
    parameter int LFSR_W       = 15,
    parameter int DITH_MIN_DEN = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DEN_W-1:0]        frac_num,
    input  logic [DEN_W-1:0]        frac_den,
    input  logic [1:0]              order_code,
    input  logic [1:0]              dither_code,
    output logic signed [OUT_W-1:0] div_offset
);
    localparam int NST   = DSM_MAX_ORDER;
    localparam int SUM_W = DEN_W + 3;

    typedef struct packed {
        logic [DEN_W-1:0] den;
        order_e           order;
    } cfg_t;

    cfg_t                    cfg_q;
    logic                    dith_ok;
    carry_t                  dith_step;
    logic signed [SUM_W-1:0] feed   [NST];
    logic [DEN_W-1:0]        acc_nx [NST];
    carry_t                  cy     [NST];

    // Modulus and order are only sampled while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.den   <= frac_den;
            cfg_q.order <= order_decode(order_code);
        end
    end

    assign dith_ok = (cfg_q.den >= DEN_W'(DITH_MIN_DEN));

    dsm_dither #(
        .LFSR_W(LFSR_W)
    ) u_dither (
        .clk   (clk),
        .rst   (rst),
        .level (dith_e'(dither_code)),
        .allow (dith_ok),
        .step  (dith_step)
    );

    generate
        for (genvar k = 0; k < NST; k++) begin : g_stage
            if (k == 0) begin : g_feed_num
                assign feed[k] = $signed({3'b000, frac_num}) + SUM_W'(dith_step);
            end else begin : g_feed_res
                assign feed[k] = $signed({3'b000, acc_nx[k-1]});
            end

            dsm_stage #(
                .DEN_W (DEN_W),
                .HEAD  (k == 0)
            ) u_stage (
                .clk     (clk),
                .rst     (rst),
                .active  (stage_on(cfg_q.order, k)),
                .addend  (feed[k]),
                .modulus (cfg_q.den),
                .acc_nx  (acc_nx[k]),
                .carry   (cy[k])
            );
        end
    endgenerate

    dsm_combiner #(
        .NST   (NST),
        .OUT_W (OUT_W)
    ) u_comb (
        .clk (clk),
        .rst (rst),
        .cy  (cy),
        .y_q (div_offset)
    );

endmodule

// File: rtl/dsm_checker.sv
module dsm_checker
    import dsm_pkg::*;
#(
    parameter int DEN_W = 12,
    parameter int OUT_W = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic [DEN_W-1:0]        frac_num,
    input logic [1:0]              dither_code,
    input logic signed [OUT_W-1:0] div_offset,
    input logic [DEN_W-1:0]        den_q,
    input order_e                  ord_q,
    input logic [DEN_W-1:0]        head_acc
);
    logic zero_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_run <= 1'b1;
        end else begin
            zero_run <= zero_run && (frac_num == '0) && (dither_code == 2'd0);
        end
    end

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (div_offset == '0));

    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(den_q) && $stable(ord_q)));

    p_zero_num_r5: assert property (@(posedge clk) disable iff (rst)
        zero_run |-> (div_offset == '0));

    p_range_o2_r6: assert property (@(posedge clk) disable iff (rst)
        (ord_q == ORDER_2 && $past(dither_code, 1) == 2'd0 && $past(dither_code, 2) == 2'd0)
        |-> (div_offset >= -1 && div_offset <= 2));

    p_range_o3_r6: assert property (@(posedge clk) disable iff (rst)
        (ord_q == ORDER_3 && $past(dither_code, 1) == 2'd0 && $past(dither_code, 2) == 2'd0)
        |-> (div_offset >= -3 && div_offset <= 4));

    p_range_o4_r6: assert property (@(posedge clk) disable iff (rst)
        (ord_q == ORDER_4 && $past(dither_code, 1) == 2'd0 && $past(dither_code, 2) == 2'd0)
        |-> (div_offset >= -7 && div_offset <= 8));

    p_head_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (den_q != '0) |-> (head_acc < den_q));

endmodule

bind frac_dsm dsm_checker #(
    .DEN_W (DEN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frac_num    (frac_num),
    .dither_code (dither_code),
    .div_offset  (div_offset),
    .den_q       (cfg_q.den),
    .ord_q       (cfg_q.order),
    .head_acc    (acc_nx[0])
);

// File: tb/sim_frac_dsm.sv
module sim_frac_dsm;
    localparam int DW = 12;
    localparam int OW = 5;

    logic                 clk   = 1'b0;
    logic                 rst   = 1'b1;
    logic [DW-1:0]        num   = '0;
    logic [DW-1:0]        den   = DW'(10);
    logic [1:0]           ocode = 2'd3;
    logic [1:0]           dcode = 2'd0;
    logic signed [OW-1:0] off;

    frac_dsm #(.DEN_W(DW), .OUT_W(OW)) u0 (
        .clk         (clk),
        .rst         (rst),
        .frac_num    (num),
        .frac_den    (den),
        .order_code  (ocode),
        .dither_code (dcode),
        .div_offset  (off)
    );

    always #10 clk = ~clk;

    int checks   = 0;
    int errors   = 0;
    bit finished = 1'b0;

    // Behavioural reference: integer residues and carry histories.
    int m_acc [4];
    int m_h2;
    int m_h3 [2];
    int m_h4 [3];
    int m_lfsr, m_dprev, m_den, m_ord, exp_off;

    always @(posedge clk) begin : ref_model
        int s, d, db;
        int c [4];
        if (rst) begin
            m_den = int'(den);
            case (ocode)
                2'd2:    m_ord = 2;
                2'd0:    m_ord = 4;
                default: m_ord = 3;
            endcase
            for (int k = 0; k < 4; k++) m_acc[k] = 0;
            m_h2 = 0;
            m_h3[0] = 0; m_h3[1] = 0;
            m_h4[0] = 0; m_h4[1] = 0; m_h4[2] = 0;
            m_lfsr  = 1;
            m_dprev = 0;
            exp_off = 0;
        end else begin
            db = 0;
            if (m_den >= 4) begin
                if (dcode == 2'd1) db = m_lfsr % 2;
                else if (dcode >= 2'd2) db = m_lfsr % 4;
            end
            d = db - m_dprev;
            m_dprev = db;
            s = m_acc[0] + int'(num) + d;
            if (s < 0) c[0] = -1;
            else if (s >= 2 * m_den) c[0] = 2;
            else if (s >= m_den) c[0] = 1;
            else c[0] = 0;
            m_acc[0] = s - c[0] * m_den;
            for (int k = 1; k < 4; k++) begin
                if (k < m_ord) begin
                    s = m_acc[k] + m_acc[k-1];
                    c[k] = (s >= m_den) ? 1 : 0;
                    m_acc[k] = s - c[k] * m_den;
                end else begin
                    c[k] = 0;
                    m_acc[k] = 0;
                end
            end
            exp_off = c[0] + (c[1] - m_h2) + (c[2] - 2 * m_h3[0] + m_h3[1])
                    + (c[3] - 3 * m_h4[0] + 3 * m_h4[1] - m_h4[2]);
            m_h2 = c[1];
            m_h3[1] = m_h3[0]; m_h3[0] = c[2];
            m_h4[2] = m_h4[1]; m_h4[1] = m_h4[0]; m_h4[0] = c[3];
            m_lfsr = ((m_lfsr << 1) & 32'h7fff) | (((m_lfsr >> 14) ^ (m_lfsr >> 13)) & 1);
        end
    end

    task automatic tally(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R1: output reads zero right after the reset edge.
    task automatic do_reset(input int n, input int dn, input logic [1:0] oc, input logic [1:0] dc);
        @(negedge clk);
        num   = DW'(n);
        den   = DW'(dn);
        ocode = oc;
        dcode = dc;
        rst   = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        tally(int'(off) == 0, "R1", int'(off), 0);
    endtask

    // Cycle-by-cycle comparison; optional bound check when lo <= hi.
    task automatic run(input int n, input string tag, input int lo, input int hi,
                       input string rtag, output int total);
        total = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tally(int'(off) == exp_off, tag, int'(off), exp_off);
            if (lo <= hi) begin
                tally(int'(off) >= lo && int'(off) <= hi, rtag, int'(off), (int'(off) < lo) ? lo : hi);
            end
            total += int'(off);
        end
    endtask

    task automatic mean_ok(input int total, input int k, input int n, input string tag);
        int dev;
        dev = total - k * n;
        if (dev < 0) dev = -dev;
        tally(dev <= 4, tag, total, k * n);
    endtask

    initial begin : main
        int t;
        logic [1:0] oc;
        int lo, hi;

        do_reset(1, 10, 2'd3, 2'd0);
        run(20, "R10", 1, 0, "", t);
        mean_ok(t, 2, 1, "R4");

        for (int oi = 0; oi < 3; oi++) begin
            if (oi == 0) begin oc = 2'd2; lo = -1; hi = 2; end
            else if (oi == 1) begin oc = 2'd3; lo = -3; hi = 4; end
            else begin oc = 2'd0; lo = -7; hi = 8; end
            do_reset(1, 10, oc, 2'd0);
            run(40, "R2", lo, hi, "R6", t);
            mean_ok(t, 4, 1, "R4");
            do_reset(400, 4000, oc, 2'd0);
            run(4000, "R2", lo, hi, "R6", t);
            mean_ok(t, 1, 400, "R4");
            do_reset(7, 13, oc, 2'd0);
            run(65, "R9", lo, hi, "R6", t);
            mean_ok(t, 5, 7, "R4");
            do_reset(4094, 4095, oc, 2'd0);
            run(4095, "R9", lo, hi, "R6", t);
            mean_ok(t, 1, 4094, "R4");
        end

        // R5: zero numerator, dither off
        do_reset(0, 9, 2'd3, 2'd0);
        run(60, "R5", 0, 0, "R5", t);
        do_reset(0, 4000, 2'd0, 2'd0);
        run(60, "R5", 0, 0, "R5", t);

        // R2: spare code 1 behaves as third order
        do_reset(5, 12, 2'd1, 2'd0);
        run(120, "R2", -3, 4, "R2", t);
        mean_ok(t, 10, 5, "R2");

        // R3: config inputs change after reset; captured values must persist
        do_reset(3, 10, 2'd2, 2'd0);
        den   = DW'(7);
        ocode = 2'd0;
        run(30, "R3", -1, 2, "R3", t);
        mean_ok(t, 3, 3, "R3");

        // R7: dither levels, switched live
        do_reset(5, 16, 2'd3, 2'd1);
        run(300, "R7", 1, 0, "", t);
        dcode = 2'd2;
        run(300, "R7", 1, 0, "", t);
        dcode = 2'd3;
        run(300, "R7", 1, 0, "", t);
        dcode = 2'd0;
        run(50, "R7", 1, 0, "", t);

        // R9: head-stage borrow and double carry under strong dither
        do_reset(15, 16, 2'd0, 2'd2);
        run(300, "R9", 1, 0, "", t);
        do_reset(0, 16, 2'd0, 2'd2);
        run(300, "R9", 1, 0, "", t);
        do_reset(1, 4, 2'd3, 2'd2);
        run(200, "R9", 1, 0, "", t);

        // R8: denominator below 4 suppresses dither
        do_reset(1, 3, 2'd3, 2'd2);
        run(30, "R8", -3, 4, "R8", t);
        mean_ok(t, 10, 1, "R8");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule